// File: doc/BRIEF.md
# Three-Sample Agreement Output Filter

This block cleans up a single-bit serial stream that is sampled once per clock whenever a valid strobe is high. Its output holds a level and moves to the opposite level only after the input has disagreed with that level on three valid samples in a row. Any valid sample that matches the held level cancels the run, so isolated glitches and short bursts never reach the output.

The filter is a Mealy machine. The output follows the input in the same cycle as the sample that completes a run of three, not one clock later. After reset there is no held level yet, so the first valid sample sets the output directly in its own cycle. Cycles with the strobe low are skipped entirely: they neither extend nor break a run, and the input bit is ignored in those cycles.

Top module: `agree3_filter`

## Requirements
- R1: After reset, and before the first valid sample, `filt_out` is 0 whatever `smp_bit` carries.
- R2: The first valid sample after reset drives `filt_out` to that sample's value in the same cycle, and the output holds that value afterwards.
- R3: With the held level 1, the third consecutive valid 0 sample drives `filt_out` to 0 in that sample's cycle, and the level stays 0 after it. The first and second such samples leave the output at 1.
- R4: With the held level 0, the third consecutive valid 1 sample drives `filt_out` to 1 in that sample's cycle, and the level stays 1 after it.
- R5: A valid sample equal to the held level cancels the run of opposing samples, so three further opposing samples are needed for a change.
- R6: While `smp_vld` is low, `filt_out` equals the held level, `smp_bit` has no effect, and the run count is kept. Opposing samples separated only by invalid cycles still count as consecutive.
- R7: After an output change the run count starts again from zero, so the next change needs three new opposing samples.
- R8: Asserting reset after operation returns the block to its initial condition: the output is 0 again and the next valid sample sets it directly.
- R9: While no level is held yet, an input bit presented with `smp_vld` low does not set the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | High when `smp_bit` carries a sample this cycle |
| smp_bit | input | 1 | Serial input sample |
| filt_out | output | 1 | Filtered level (Mealy, combinational from the current sample) |

## Verification
The assertions assume that `smp_vld` and `smp_bit` are stable and known around each rising clock edge, and that `rst_n` is held low for at least one edge before operation starts. Under these assumptions each check of a state hold or a run restart follows one edge after its cause. The bench changes inputs only just after the falling edge. It reads the combinational output a short time later, before the next rising edge. It holds reset across two edges at start-up and in mid-run.

// File: rtl/agree3_pkg.sv
// Package: shared constants and phase encoding for the agreement filter.
// Assumes the run length is small; the counter width is derived from it.
package agree3_pkg;
    localparam int RUN_LEN = 3;
    localparam int CNT_W   = $clog2(RUN_LEN);

    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/agree3_cmp.sv
// Module: compares the incoming sample against the held level.
// Assumes the phase input comes from the filter's phase register.
module agree3_cmp
    import agree3_pkg::*;
(
    input  phase_e phase,
    input  logic   smp_bit,
    output logic   armed,
    output logic   level,
    output logic   oppose
);
    // Decode the held level and flag a disagreeing sample.
    always_comb begin
        armed  = (phase != PH_INIT);
        level  = (phase == PH_HIGH);
        oppose = armed && (smp_bit != level);
    end
endmodule

// File: rtl/agree3_run.sv
// Module: counts consecutive valid samples that oppose the held level and
// raises trip on the one that completes the run. Assumes oppose is only
// meaningful while armed is high.
module agree3_run
    import agree3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic armed,
    input  logic oppose,
    output logic trip
);
    logic [CNT_W-1:0] cnt_q;

    // Trip when the final opposing sample of a run arrives.
    always_comb begin
        trip = smp_vld && armed && oppose && (cnt_q == CNT_W'(RUN_LEN - 1));
    end

    // Advance, clear or hold the run count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (smp_vld && armed) begin
            if (!oppose || trip) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    agree_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && armed && !oppose) |=> (cnt_q == '0));
    // R6
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(cnt_q));
    // R7
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (cnt_q == '0));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < CNT_W'(RUN_LEN)));
endmodule

// File: rtl/agree3_filter.sv
// Module: top of the three-sample agreement filter. Holds the phase
// (initial, low, high) and produces the Mealy output. Assumes inputs are
// synchronous to clk and reset is synchronous, active low.
module agree3_filter
    import agree3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic smp_bit,
    output logic filt_out
);
    phase_e phase_q;
    phase_e phase_d;
    logic   armed;
    logic   level;
    logic   oppose;
    logic   trip;

    agree3_cmp u_cmp (
        .phase  (phase_q),
        .smp_bit(smp_bit),
        .armed  (armed),
        .level  (level),
        .oppose (oppose)
    );

    agree3_run u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_vld(smp_vld),
        .armed  (armed),
        .oppose (oppose),
        .trip   (trip)
    );

    // Choose the next phase: seed on the first sample, flip on a trip.
    always_comb begin
        phase_d = phase_q;
        if (smp_vld) begin
            if (!armed)   phase_d = smp_bit ? PH_HIGH : PH_LOW;
            else if (trip) phase_d = level ? PH_LOW : PH_HIGH;
        end
    end

    // Mealy output: the current sample passes when it seeds or trips.
    always_comb begin
        if (smp_vld && (!armed || trip)) filt_out = smp_bit;
        else                             filt_out = level;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_INIT;
        else        phase_q <= phase_d;
    end

    // R1
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_INIT && !smp_vld) |-> !filt_out);
    // R2
    first_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_INIT && smp_vld) |=> (phase_q == (smp_bit_q ? PH_HIGH : PH_LOW)));
    // R6
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(phase_q));
    // R3
    no_flip_without_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !trip) |=> $stable(phase_q));

    // Registered copy of the sample, used only by first_sample_chk.
    logic smp_bit_q;
    always_ff @(posedge clk) begin
        smp_bit_q <= smp_bit;
    end
endmodule

// File: tb/agree3_filter_bench.sv
module agree3_filter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic smp_bit = 1'b0;
    logic filt_out;
    int   checks = 0;
    int   errors = 0;

    agree3_filter u_agree3_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .smp_bit (smp_bit),
        .filt_out(filt_out)
    );

    always #2.5 clk = ~clk;

    // Drive one cycle, check the Mealy output before the rising edge.
    task automatic step(input logic v, input logic b, input logic exp, input string tag);
        @(negedge clk);
        smp_vld = v;
        smp_bit = b;
        #1;
        checks++;
        if (filt_out !== exp) begin
            errors++;
            $display("FAIL %s: filt_out=%0b expected=%0b", tag, filt_out, exp);
        end
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_vld = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        step(0, 1, 0, "R1 idle after reset");
        step(0, 1, 0, "R9 invalid bit ignored in initial state");
        step(0, 0, 0, "R1 output zero before first sample");
    endtask

    task automatic t_seed_and_rise_fall();
        do_reset();
        step(1, 0, 0, "R2 first sample 0");
        step(1, 1, 0, "R4 first opposing");
        step(1, 1, 0, "R4 second opposing");
        step(1, 1, 1, "R4 third opposing flips to 1");
        step(0, 0, 1, "R4 level held at 1");
        step(1, 0, 1, "R3 first 0");
        step(1, 0, 1, "R3 second 0");
        step(1, 0, 0, "R3 third 0 flips to 0");
        step(0, 1, 0, "R3 level held at 0");
    endtask

    task automatic t_seed_one();
        do_reset();
        step(1, 1, 1, "R2 first sample 1");
        step(0, 0, 1, "R2 seed held");
        step(1, 1, 1, "R2 agreeing sample keeps 1");
    endtask

    task automatic t_agree_restart();
        do_reset();
        step(1, 0, 0, "R5 seed 0");
        step(1, 1, 0, "R5 run 1");
        step(1, 1, 0, "R5 run 2");
        step(1, 0, 0, "R5 agreeing sample cancels");
        step(1, 1, 0, "R5 new run 1");
        step(1, 1, 0, "R5 new run 2");
        step(1, 1, 1, "R5 new run 3 flips");
    endtask

    task automatic t_gaps();
        do_reset();
        step(1, 1, 1, "R6 seed 1");
        step(1, 0, 1, "R6 run 1");
        step(0, 1, 1, "R6 invalid 1 ignored");
        step(0, 0, 1, "R6 invalid 0 ignored");
        step(1, 0, 1, "R6 run 2 across gap");
        step(0, 1, 1, "R6 invalid again");
        step(1, 0, 0, "R6 run 3 across gaps flips");
    endtask

    task automatic t_after_change();
        do_reset();
        step(1, 1, 1, "R7 seed 1");
        step(1, 0, 1, "R7 a");
        step(1, 0, 1, "R7 b");
        step(1, 0, 0, "R7 flip to 0");
        step(1, 1, 0, "R7 fresh run 1");
        step(1, 1, 0, "R7 fresh run 2");
        step(1, 1, 1, "R7 fresh run 3 flips");
        step(1, 1, 1, "R7 stays 1");
    endtask

    task automatic t_mid_reset();
        do_reset();
        step(1, 1, 1, "R8 seed 1");
        step(1, 0, 1, "R8 partial run");
        do_reset();
        step(0, 1, 0, "R8 output back to 0");
        step(1, 0, 0, "R8 reseed 0");
        step(1, 1, 0, "R8 run restarted 1");
        step(1, 1, 0, "R8 run restarted 2");
        step(1, 1, 1, "R8 run restarted 3");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: expired, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_seed_and_rise_fall();
        t_seed_one();
        t_agree_restart();
        t_gaps();
        t_after_change();
        t_mid_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule